// File: doc/BRIEF.md
# DDR Bank Read-to-Precharge Rule Monitor

This block sits beside a DDR SDRAM controller and watches the decoded command stream it sends to the memory: one command per clock, one of NOP, ACTIVE, READ or PRECHARGE, with a bank number and a modifier flag. For a READ the flag asks for auto-precharge. For a PRECHARGE it selects all banks instead of the named one. The monitor keeps a small record per bank: whether a row is open, how long ago the last READ was issued, whether an auto-precharge is pending, and how much of the precharge recovery time is left. From this record it judges each command. When a command breaks a rule it raises a one-cycle violation pulse with a code and the bank at fault. When a PRECHARGE legally cuts a long burst short, it raises a truncation pulse instead.

The command stream is observed, never steered. There is no handshake and no back-pressure, because the monitor accepts a command on every clock and NOP stands for the idle cycle. A rejected command leaves the bank record untouched, so one mistake does not cascade into false reports on later commands. Three configuration inputs set the rules: burst length (4 or 8), recovery time in clocks, and CAS latency (2 or 2.5). The CAS latency setting is accepted for completeness and does not change any rule checked here.

Command encoding is 0 NOP, 1 ACTIVE, 2 READ, 3 PRECHARGE. Violation codes are 1 ACTIVE to an open bank, 2 ACTIVE during recovery, 3 READ during recovery, 4 READ to a bank that is closed or closing, 5 PRECHARGE during recovery, 6 explicit PRECHARGE while auto-precharge is pending, and 7 PRECHARGE fewer than 2 clocks after a READ. Every output is registered and reports the command sampled on the previous rising edge.

Top module: `ddr_rdpre_checker`

## Requirements
- R1: After reset every bank is closed and idle, and viol_pulse and trunc_mask are 0.
- R2: ACTIVE to a closed bank that has finished recovery opens it with no report. ACTIVE to an open bank reports code 1.
- R3: After a bank closes on the edge of cycle p, ACTIVE to it in cycles p+1 to p+cfg_trp-1 reports code 2. ACTIVE in cycle p+cfg_trp is accepted.
- R4: During that same recovery window, READ reports code 3 and PRECHARGE reports code 5.
- R5: READ to a closed bank, or to a bank with an auto-precharge still pending, reports code 4.
- R6: PRECHARGE to a bank 1 clock after a READ to it reports code 7. At 2 clocks or more it is accepted, for both burst lengths.
- R7: An accepted PRECHARGE 2 or 3 clocks after a burst-length-8 READ sets the bank's bit in trunc_mask (bit i is bank i) for one cycle, with no violation. No truncation is reported at 2 clocks for burst length 4, or at 4 clocks for burst length 8.
- R8: A READ with the flag set in cycle r closes the bank in cycle r+BL/2 while it stays open before that. Recovery counts from there, so ACTIVE is first accepted in cycle r+BL/2+cfg_trp.
- R9: An explicit PRECHARGE to a bank with an auto-precharge pending reports code 6.
- R10: PRECHARGE with the flag set judges every bank. If any bank breaks a rule, it reports the code of the lowest-numbered such bank. Otherwise it closes every open bank and starts its recovery, and leaves closed banks untouched.
- R11: A violation is a one-cycle pulse with a nonzero code and the bank, one clock after the command. The rejected command changes no bank state.
- R12: NOP produces no report and changes no bank state. The CAS latency setting changes no outcome.
- R13: PRECHARGE to a closed bank that has finished recovery is accepted with no report and starts no recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: 0 NOP, 1 ACTIVE, 2 READ, 3 PRECHARGE |
| cmd_bank | input | BANK_W (2) | Target bank |
| cmd_flag | input | 1 | READ: auto-precharge; PRECHARGE: all banks |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_cl_half | input | 1 | 1 selects CAS latency 2.5, 0 selects 2 |
| cfg_trp | input | TRP_W (4) | Precharge recovery time in clocks |
| viol_pulse | output | 1 | One-cycle rule violation pulse |
| viol_code | output | 3 | Violation code (see above) |
| viol_bank | output | BANK_W (2) | Bank at fault |
| trunc_mask | output | NBANK (4) | One-cycle burst truncation, one bit per bank |

## Verification
The READ-to-PRECHARGE spacing is driven at 1, 2, 3 and 4 clocks under both burst lengths. These points separate a hard violation, a legal truncation and a plain legal close. Recovery is probed one clock before and exactly at the boundary, after an explicit precharge, after an auto-precharge of either burst length, and after an all-bank precharge, so an off-by-one in the counter load or in the firing point shows up. The all-bank patterns mix open, closed and recovering banks, which tells the lowest-bank priority apart from a plain bank scan. Follow-up commands after each rejected command show that no state moved. A closing pass repeats a legal sequence with the other CAS latency and idle stretches.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    V_NONE     = 3'd0,
    V_ACT_OPEN = 3'd1,
    V_ACT_TRP  = 3'd2,
    V_RD_TRP   = 3'd3,
    V_RD_IDLE  = 3'd4,
    V_PRE_TRP  = 3'd5,
    V_PRE_AP   = 3'd6,
    V_RD2PRE   = 3'd7
  } viol_e;

  // half burst lengths: data-pair clocks of each burst setting
  localparam int BL4_HALF = 2;
  localparam int BL8_HALF = 4;

endpackage

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_chk_pkg::*;
#(
  parameter int TRP_W      = 4,
  parameter int AGE_W      = 3,
  parameter int RD2PRE_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bl8,
  input  logic [TRP_W-1:0] cfg_trp,
  input  logic             act_go,
  input  logic             rd_go,
  input  logic             rd_ap,
  input  logic             pre_go,
  output logic             is_open,
  output logic             trp_busy,
  output logic             ap_pend,
  output logic             pre_short,
  output logic             pre_trunc
);

  localparam int AP_W = $clog2(BL8_HALF);

  logic             open_q;
  logic             ap_q;
  logic [AP_W-1:0]  apcnt_q;
  logic [TRP_W-1:0] trp_q;
  logic [AGE_W-1:0] age_q;
  logic             rbl8_q;

  logic             ap_fire;
  logic [TRP_W-1:0] trp_load;
  logic [AP_W-1:0]  ap_load;
  logic [AGE_W-1:0] half_age;

  assign ap_fire  = ap_q && (apcnt_q == '0);
  assign trp_load = (cfg_trp == '0) ? '0 : cfg_trp - 1'b1;
  assign ap_load  = cfg_bl8 ? AP_W'(BL8_HALF - 1) : AP_W'(BL4_HALF - 1);
  assign half_age = rbl8_q ? AGE_W'(BL8_HALF) : AGE_W'(BL4_HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      ap_q    <= 1'b0;
      apcnt_q <= '0;
      trp_q   <= '0;
      age_q   <= '1;
      rbl8_q  <= 1'b0;
    end else begin
      if (pre_go || ap_fire) begin
        // explicit or implied precharge: bank closes, recovery starts
        open_q <= 1'b0;
        ap_q   <= 1'b0;
        trp_q  <= trp_load;
      end else begin
        if (trp_q != '0) trp_q <= trp_q - 1'b1;
        if (act_go) open_q <= 1'b1;
        if (rd_go && rd_ap) begin
          ap_q    <= 1'b1;
          apcnt_q <= ap_load;
        end else if (ap_q) begin
          apcnt_q <= apcnt_q - 1'b1;
        end
      end
      // clocks since the last READ, saturating; a new row forgets it
      if (rd_go) begin
        age_q  <= AGE_W'(1);
        rbl8_q <= cfg_bl8;
      end else if (act_go) begin
        age_q <= '1;
      end else if (age_q != '1) begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  assign is_open   = open_q;
  assign trp_busy  = (trp_q != '0);
  assign ap_pend   = ap_q;
  assign pre_short = (age_q < AGE_W'(RD2PRE_MIN));
  assign pre_trunc = (age_q < half_age);

  // R8: an implied precharge closes the bank and loads recovery
  p_ap_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ap_fire |=> !open_q && (trp_q == $past(trp_load)));

  // R3: the judge only opens a bank that is closed and recovered
  p_act_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> !open_q && (trp_q == '0));

  // R13: an accepted precharge only ever lands on an open bank
  p_pre_open_r13: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |-> open_q && !ap_q);

  // R5: a pending auto-precharge implies an open bank
  p_ap_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ap_q |-> open_q);

  // R11: at most one state change request per bank per cycle
  p_go_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_go, rd_go, pre_go}));

endmodule

// File: rtl/ddr_cmd_judge.sv
module ddr_cmd_judge
  import ddr_chk_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              flag,
  input  logic [NBANK-1:0]  open_v,
  input  logic [NBANK-1:0]  busy_v,
  input  logic [NBANK-1:0]  ap_v,
  input  logic [NBANK-1:0]  short_v,
  input  logic [NBANK-1:0]  trunc_v,
  output logic [NBANK-1:0]  act_go,
  output logic [NBANK-1:0]  rd_go,
  output logic [NBANK-1:0]  pre_go,
  output logic [NBANK-1:0]  trunc_go,
  output viol_e             code,
  output logic [BANK_W-1:0] code_bank
);

  function automatic viol_e bank_rule(input cmd_e c, input logic op,
                                      input logic bz, input logic ap,
                                      input logic sh);
    viol_e r;
    r = V_NONE;
    case (c)
      CMD_ACT: if (op) r = V_ACT_OPEN; else if (bz) r = V_ACT_TRP;
      CMD_RD:  if (bz) r = V_RD_TRP; else if (!op || ap) r = V_RD_IDLE;
      CMD_PRE: if (bz) r = V_PRE_TRP;
               else if (ap) r = V_PRE_AP;
               else if (op && sh) r = V_RD2PRE;
      default: r = V_NONE;
    endcase
    return r;
  endfunction

  logic [NBANK-1:0] hit;
  logic             any_viol;

  always_comb begin
    for (int i = 0; i < NBANK; i++) begin
      hit[i] = (bank == BANK_W'(i)) || ((cmd == CMD_PRE) && flag);
    end
  end

  // lowest offending bank wins: scan downward, last write stands
  always_comb begin
    viol_e c;
    code      = V_NONE;
    code_bank = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      c = bank_rule(cmd, open_v[i], busy_v[i], ap_v[i], short_v[i]);
      if (hit[i] && (c != V_NONE)) begin
        code      = c;
        code_bank = BANK_W'(i);
      end
    end
  end

  assign any_viol = (code != V_NONE);

  always_comb begin
    for (int i = 0; i < NBANK; i++) begin
      act_go[i]   = !any_viol && hit[i] && (cmd == CMD_ACT);
      rd_go[i]    = !any_viol && hit[i] && (cmd == CMD_RD);
      pre_go[i]   = !any_viol && hit[i] && (cmd == CMD_PRE) && open_v[i];
      trunc_go[i] = pre_go[i] && trunc_v[i];
    end
  end

endmodule

// File: rtl/ddr_rdpre_checker.sv
module ddr_rdpre_checker
  import ddr_chk_pkg::*;
#(
  parameter int NBANK      = 4,
  parameter int TRP_W      = 4,
  parameter int AGE_W      = 3,
  parameter int RD2PRE_MIN = 2,
  localparam int BANK_W    = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_flag,
  input  logic              cfg_bl8,
  input  logic              cfg_cl_half,
  input  logic [TRP_W-1:0]  cfg_trp,
  output logic              viol_pulse,
  output logic [2:0]        viol_code,
  output logic [BANK_W-1:0] viol_bank,
  output logic [NBANK-1:0]  trunc_mask
);

  cmd_e              cmd_t;
  logic [NBANK-1:0]  open_v, busy_v, ap_v, short_v, trunc_v;
  logic [NBANK-1:0]  act_go, rd_go, pre_go, trunc_go;
  viol_e             code;
  logic [BANK_W-1:0] code_bank;

  assign cmd_t = cmd_e'(cmd);

  ddr_cmd_judge #(.NBANK(NBANK), .BANK_W(BANK_W)) u_judge (
    .cmd      (cmd_t),
    .bank     (cmd_bank),
    .flag     (cmd_flag),
    .open_v   (open_v),
    .busy_v   (busy_v),
    .ap_v     (ap_v),
    .short_v  (short_v),
    .trunc_v  (trunc_v),
    .act_go   (act_go),
    .rd_go    (rd_go),
    .pre_go   (pre_go),
    .trunc_go (trunc_go),
    .code     (code),
    .code_bank(code_bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr_bank_tracker #(
      .TRP_W(TRP_W), .AGE_W(AGE_W), .RD2PRE_MIN(RD2PRE_MIN)
    ) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_bl8  (cfg_bl8),
      .cfg_trp  (cfg_trp),
      .act_go   (act_go[b]),
      .rd_go    (rd_go[b]),
      .rd_ap    (cmd_flag),
      .pre_go   (pre_go[b]),
      .is_open  (open_v[b]),
      .trp_busy (busy_v[b]),
      .ap_pend  (ap_v[b]),
      .pre_short(short_v[b]),
      .pre_trunc(trunc_v[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_pulse <= 1'b0;
      viol_code  <= 3'd0;
      viol_bank  <= '0;
      trunc_mask <= '0;
    end else begin
      viol_pulse <= (code != V_NONE);
      viol_code  <= code;
      viol_bank  <= code_bank;
      trunc_mask <= trunc_go;
    end
  end

  // R12: the latency setting is a legal configuration value only
  always_comb begin
    if (rst_n) a_cl_known_r12: assert (!$isunknown(cfg_cl_half));
  end

  // R11: a pulse always carries a real code
  p_code_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (viol_code != 3'd0));

  // R7: truncation is a legal outcome, never paired with a violation
  p_trunc_no_viol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trunc_mask != '0) |-> !viol_pulse);

  // R12: an idle command gives a quiet next cycle
  p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_t == CMD_NOP) |=> !viol_pulse && (trunc_mask == '0));

  // R7: only precharge commands may report a truncation
  p_trunc_from_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_t != CMD_PRE) |=> (trunc_mask == '0));

endmodule

// File: tb/ddr_rdpre_checker_tb.sv
module ddr_rdpre_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, PRE = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cmd;
  logic [1:0] cmd_bank;
  logic       cmd_flag;
  logic       cfg_bl8;
  logic       cfg_cl_half;
  logic [3:0] cfg_trp;
  logic       viol_pulse;
  logic [2:0] viol_code;
  logic [1:0] viol_bank;
  logic [3:0] trunc_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr_rdpre_checker u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_flag(cmd_flag), .cfg_bl8(cfg_bl8), .cfg_cl_half(cfg_cl_half),
    .cfg_trp(cfg_trp), .viol_pulse(viol_pulse), .viol_code(viol_code),
    .viol_bank(viol_bank), .trunc_mask(trunc_mask)
  );

  task automatic chk(input string tag, input logic ev, input logic [2:0] ec,
                     input logic [1:0] eb, input logic [3:0] et);
    n_chk++;
    if (viol_pulse !== ev || trunc_mask !== et ||
        (ev && (viol_code !== ec || viol_bank !== eb))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b code=%0d bank=%0d trunc=%b, expected v=%0b code=%0d bank=%0d trunc=%b",
               tag, viol_pulse, viol_code, viol_bank, trunc_mask, ev, ec, eb, et);
    end
  endtask

  // drive at a falling edge; result is visible at the next falling edge
  task automatic op(input logic [1:0] c, input logic [1:0] b, input logic f);
    cmd = c; cmd_bank = b; cmd_flag = f;
    @(negedge clk);
    cmd = NOP; cmd_bank = 2'd0; cmd_flag = 1'b0;
  endtask

  task automatic ok(input string tag);
    chk(tag, 1'b0, 3'd0, 2'd0, 4'b0000);
  endtask

  task automatic bad(input string tag, input logic [2:0] c, input logic [1:0] b);
    chk(tag, 1'b1, c, b, 4'b0000);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      op(NOP, 2'd0, 1'b0); ok("R12 nop quiet");
    end
  endtask

  task automatic t_reset;
    ok("R1 reset outputs");
    op(RD, 2'd0, 1'b0); bad("R1 R5 read closed after reset", 3'd4, 2'd0);
  endtask

  task automatic t_act;
    op(ACT, 2'd0, 1'b0); ok("R2 open bank0");
    op(ACT, 2'd0, 1'b0); bad("R2 act to open bank", 3'd1, 2'd0);
    op(ACT, 2'd1, 1'b0); ok("R2 open bank1");
  endtask

  task automatic t_rdpre;
    op(RD, 2'd0, 1'b0);  ok("R6 read bank0");
    op(PRE, 2'd0, 1'b0); bad("R6 pre 1 clk after read", 3'd7, 2'd0);
    op(PRE, 2'd0, 1'b0); ok("R6 R7 R11 pre 2 clk bl4 accepted, no trunc");
    op(PRE, 2'd1, 1'b0); ok("R6 pre bank1");
    op(ACT, 2'd0, 1'b0); bad("R3 act in trp", 3'd2, 2'd0);
    op(PRE, 2'd1, 1'b0); bad("R4 pre in trp", 3'd5, 2'd1);
    op(ACT, 2'd1, 1'b0); ok("R3 act at trp boundary");
    op(ACT, 2'd0, 1'b0); ok("R3 act after trp");
    op(PRE, 2'd2, 1'b0); ok("R13 pre closed bank");
    op(ACT, 2'd2, 1'b0); ok("R13 no trp from idle pre");
  endtask

  task automatic t_trunc;
    cfg_bl8 = 1'b1;
    op(RD, 2'd0, 1'b0);  ok("R7 read bl8 bank0");
    op(NOP, 2'd0, 1'b0); ok("R12 nop");
    op(PRE, 2'd0, 1'b0); chk("R7 trunc at 2 clk", 1'b0, 3'd0, 2'd0, 4'b0001);
    op(RD, 2'd1, 1'b0);  ok("R7 read bl8 bank1");
    idle(3);
    op(PRE, 2'd1, 1'b0); ok("R7 no trunc at 4 clk");
    op(RD, 2'd2, 1'b0);  ok("R7 read bl8 bank2");
    op(PRE, 2'd2, 1'b0); bad("R6 bl8 pre 1 clk", 3'd7, 2'd2);
    op(NOP, 2'd0, 1'b0); ok("R12 nop");
    op(PRE, 2'd2, 1'b0); chk("R7 trunc at 3 clk", 1'b0, 3'd0, 2'd0, 4'b0100);
    cfg_bl8 = 1'b0;
    idle(4);
  endtask

  task automatic t_ap;
    op(ACT, 2'd3, 1'b0); ok("R8 open bank3");
    op(RD, 2'd3, 1'b1);  ok("R8 read ap bl4");
    op(PRE, 2'd3, 1'b0); bad("R9 pre with ap pending", 3'd6, 2'd3);
    op(RD, 2'd3, 1'b0);  bad("R5 read with ap pending", 3'd4, 2'd3);
    op(ACT, 2'd3, 1'b0); bad("R8 act 1 clk after ap", 3'd2, 2'd3);
    op(RD, 2'd3, 1'b0);  bad("R4 read in trp", 3'd3, 2'd3);
    op(ACT, 2'd3, 1'b0); ok("R8 act at r+BL/2+trp");
    cfg_bl8 = 1'b1;
    op(RD, 2'd3, 1'b1);  ok("R8 read ap bl8");
    idle(2);
    op(ACT, 2'd3, 1'b0); bad("R8 bank open before fire", 3'd1, 2'd3);
    op(ACT, 2'd3, 1'b0); bad("R8 bank open at fire", 3'd1, 2'd3);
    op(ACT, 2'd3, 1'b0); bad("R8 bl8 act in trp", 3'd2, 2'd3);
    op(NOP, 2'd0, 1'b0); ok("R12 nop");
    op(ACT, 2'd3, 1'b0); ok("R8 bl8 act after trp");
    cfg_bl8 = 1'b0;
  endtask

  task automatic t_all;
    op(ACT, 2'd0, 1'b0); ok("R10 open bank0");
    op(ACT, 2'd1, 1'b0); ok("R10 open bank1");
    op(RD, 2'd1, 1'b0);  ok("R10 read bank1");
    op(PRE, 2'd0, 1'b1); bad("R10 all-pre too soon", 3'd7, 2'd1);
    op(PRE, 2'd0, 1'b1); ok("R10 all-pre accepted");
    op(ACT, 2'd2, 1'b0); ok("R10 closed bank untouched");
    op(PRE, 2'd0, 1'b1); bad("R10 R11 all-pre in trp lowest bank", 3'd5, 2'd0);
    op(ACT, 2'd3, 1'b0); ok("R10 bank3 trp from all-pre");
    op(ACT, 2'd2, 1'b0); bad("R11 rejected all-pre left bank2 open", 3'd1, 2'd2);
  endtask

  task automatic t_cl;
    cfg_cl_half = 1'b1;
    idle(3);
    op(RD, 2'd2, 1'b0);  ok("R12 read with cl 2.5");
    op(PRE, 2'd2, 1'b0); bad("R12 cl 2.5 same spacing rule", 3'd7, 2'd2);
    op(NOP, 2'd0, 1'b0); ok("R12 nop");
    op(PRE, 2'd2, 1'b0); ok("R12 cl 2.5 pre accepted");
    cfg_cl_half = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cmd = NOP; cmd_bank = 2'd0; cmd_flag = 1'b0;
    cfg_bl8 = 1'b0; cfg_cl_half = 1'b0; cfg_trp = 4'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_act;
    t_rdpre;
    t_trunc;
    t_ap;
    t_all;
    t_cl;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule